// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the 32-bit datapath of a processor that runs each instruction over several clock cycles. It holds the program counter, an instruction register, a memory data register, three holding registers (two operand registers and an ALU result register), a 32-entry register file and an ALU with a zero flag. It also holds every steering multiplexer between them. It makes no decisions of its own. An external sequencer drives every select and enable on each cycle and reads back the instruction word and the zero flag to pick its next step.

Instructions and data share one memory port. The address comes either from the program counter or from the saved ALU result, and store data always comes from the second operand register. Because each intermediate value is captured in a register at the end of every cycle, one ALU can compute the incremented PC, a branch target, an effective address and an arithmetic result in different cycles of the same instruction.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_n` is low, the PC, instruction, memory data, both operand registers, the result register and all 32 register-file entries are cleared to zero.
- R2: `mem_addr` is the PC when `addr_from_alu` is 0 and the result register when it is 1. `mem_wdata` is always the second operand register.
- R3: `instr` takes `mem_rdata` at a clock edge only when `ir_load` is 1 and otherwise holds. The memory data register takes `mem_rdata` at every edge.
- R4: At every edge, the first operand register loads register-file entry `instr[25:21]` and the second loads entry `instr[20:16]`, both read before that edge's write. The result register loads the live ALU result at every edge.
- R5: When `rf_we` is 1, the register file is written at the edge. The destination is `instr[20:16]` when `rf_dst_rd` is 0 and `instr[15:11]` when it is 1. The data is the result register when `rf_from_mdr` is 0 and the memory data register when it is 1. Entry 0 always reads zero.
- R6: The first ALU operand is the PC when `alu_a_reg` is 0 and the first operand register when it is 1.
- R7: `alu_b_sel` picks the second ALU operand: 0 the second operand register, 1 the constant 4, 2 the sign-extended `instr[15:0]`, 3 that value shifted left by two.
- R8: `alu_op` 000 is AND, 001 OR, 010 add, 110 subtract and 111 signed set-less-than (result 1 or 0). Any other code gives zero. `alu_zero` is 1 exactly when the live result is all zeros.
- R9: `pc_src` picks the next PC: 0 the live ALU result, 1 the result register, 2 or 3 the jump target {PC[31:28], `instr[25:0]`, 2'b00}.
- R10: The PC loads at an edge when `pc_we` is 1, or when `pc_we_zero` and `alu_zero` are both 1. Otherwise it holds.
- R11: `mem_rd` and `mem_wr` follow `mem_rd_req` and `mem_wr_req` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_from_alu | input | 1 | Memory address from the result register instead of the PC |
| ir_load | input | 1 | Load the instruction register |
| mem_rd_req | input | 1 | Memory read request |
| mem_wr_req | input | 1 | Memory write request |
| rf_we | input | 1 | Register-file write enable |
| rf_dst_rd | input | 1 | Write destination from instr[15:11] |
| rf_from_mdr | input | 1 | Write data from the memory data register |
| alu_a_reg | input | 1 | First ALU operand from the operand register |
| alu_b_sel | input | 2 | Second ALU operand select |
| pc_src | input | 2 | Next-PC source select |
| pc_we | input | 1 | Unconditional PC write |
| pc_we_zero | input | 1 | PC write qualified by the zero flag |
| alu_op | input | 3 | ALU operation code |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_rdata | input | 32 | Memory read data |
| instr | output | 32 | Instruction register contents |
| alu_zero | output | 1 | Live ALU result is zero |

## Verification
Most state is visible only indirectly. A wrong PC or result register shows on `mem_addr` in the same cycle that the matching address select is applied. A wrong operand register shows on `mem_wdata` or on `alu_zero` one cycle after it loads. A corrupted register-file entry or memory data register stays hidden until that entry is read into the second operand register, which takes one extra edge. For this reason the bench drives random control vectors over a memory model and compares every port against a behavioural model on every cycle, so a divergence is caught within one or two cycles of the first observable use.

// File: rtl/mc_datapath.sv
module mc_datapath #(
  parameter int DW = 32,
  parameter int NREG = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_from_alu,
  input  logic          ir_load,
  input  logic          mem_rd_req,
  input  logic          mem_wr_req,
  input  logic          rf_we,
  input  logic          rf_dst_rd,
  input  logic          rf_from_mdr,
  input  logic          alu_a_reg,
  input  logic [1:0]    alu_b_sel,
  input  logic [1:0]    pc_src,
  input  logic          pc_we,
  input  logic          pc_we_zero,
  input  logic [2:0]    alu_op,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] instr,
  output logic          alu_zero
);
  localparam int RW = $clog2(NREG);

  logic [DW-1:0] pc_q, ir_q, mdr_q, a_q, b_q, res_q;
  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] imm, opa, opb, res, pc_nxt, wd;
  logic [RW-1:0] wa;
  logic          pc_load;

  assign imm       = {{(DW-16){ir_q[15]}}, ir_q[15:0]};
  assign opa       = alu_a_reg ? a_q : pc_q;
  assign wa        = rf_dst_rd ? ir_q[15:11] : ir_q[20:16];
  assign wd        = rf_from_mdr ? mdr_q : res_q;
  assign pc_load   = pc_we | (pc_we_zero & alu_zero);
  assign mem_addr  = addr_from_alu ? res_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_rd    = mem_rd_req;
  assign mem_wr    = mem_wr_req;
  assign instr     = ir_q;
  assign alu_zero  = (res == '0);

  always_comb begin
    case (alu_b_sel)
      2'd0:    opb = b_q;
      2'd1:    opb = DW'(4);
      2'd2:    opb = imm;
      default: opb = {imm[DW-3:0], 2'b00};
    endcase
  end

  always_comb begin
    case (alu_op)
      3'b000:  res = opa & opb;
      3'b001:  res = opa | opb;
      3'b010:  res = opa + opb;
      3'b110:  res = opa - opb;
      3'b111:  res = {{(DW-1){1'b0}}, ($signed(opa) < $signed(opb))};
      default: res = '0;
    endcase
  end

  always_comb begin
    case (pc_src)
      2'd0:    pc_nxt = res;
      2'd1:    pc_nxt = res_q;
      default: pc_nxt = {pc_q[DW-1:28], ir_q[25:0], 2'b00};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (pc_load) pc_q <= pc_nxt;
      if (ir_load) ir_q <= mem_rdata;
      mdr_q <= mem_rdata;
      a_q   <= rf[ir_q[25:21]];
      b_q   <= rf[ir_q[20:16]];
      res_q <= res;
      if (rf_we && wa != '0) rf[wa] <= wd;
    end
  end

  p_reset_pc_r1: assert property (@(posedge clk) !rst_n |=> (pc_q == '0 && ir_q == '0));

  p_ir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_load |=> $stable(instr));

  p_a_from_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[25:21] == '0) |=> (a_q == '0));

  p_slt_bool_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 3'b111) |-> (res[DW-1:1] == '0));

  p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_we && !(pc_we_zero && alu_zero)) |=> $stable(pc_q));
endmodule

// File: tb/tb_mc_datapath.sv
module tb_mc_datapath;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_from_alu = 0, ir_load = 0, mem_rd_req = 0, mem_wr_req = 0;
  logic rf_we = 0, rf_dst_rd = 0, rf_from_mdr = 0, alu_a_reg = 0;
  logic [1:0] alu_b_sel = 0, pc_src = 0;
  logic pc_we = 0, pc_we_zero = 0;
  logic [2:0] alu_op = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, instr;
  logic mem_rd, mem_wr, alu_zero;

  logic [31:0] mem [64];
  assign mem_rdata = mem[mem_addr[7:2]];

  int checks = 0;
  int errors = 0;

  logic [31:0] m_pc, m_ir, m_mdr, m_a, m_b, m_out;
  logic [31:0] m_rf [32];

  always #(CLK_NS/2) clk = ~clk;

  mc_datapath dut (
    .clk(clk), .rst_n(rst_n), .addr_from_alu(addr_from_alu), .ir_load(ir_load),
    .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .rf_we(rf_we),
    .rf_dst_rd(rf_dst_rd), .rf_from_mdr(rf_from_mdr), .alu_a_reg(alu_a_reg),
    .alu_b_sel(alu_b_sel), .pc_src(pc_src), .pc_we(pc_we), .pc_we_zero(pc_we_zero),
    .alu_op(alu_op), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_rdata(mem_rdata), .instr(instr), .alu_zero(alu_zero));

  function automatic logic [31:0] ref_alu(input logic [2:0] op, input logic [31:0] x, input logic [31:0] y);
    int sx, sy;
    sx = int'(x);
    sy = int'(y);
    if (op == 3'b010) return x + y;
    if (op == 3'b110) return x - y;
    if (op == 3'b000) return x & y;
    if (op == 3'b001) return x | y;
    if (op == 3'b111) return (sx < sy) ? 32'd1 : 32'd0;
    return 32'd0;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic randomize_ctrl(input int mode);
    logic [2:0] ops [5];
    ops[0] = 3'b000; ops[1] = 3'b001; ops[2] = 3'b010; ops[3] = 3'b110; ops[4] = 3'b111;
    addr_from_alu = 1'($urandom_range(0, 1));
    ir_load       = ($urandom_range(0, 3) == 0);
    mem_rd_req    = 1'($urandom_range(0, 1));
    mem_wr_req    = ($urandom_range(0, 5) == 0);
    rf_we         = 1'($urandom_range(0, 1));
    rf_dst_rd     = 1'($urandom_range(0, 1));
    rf_from_mdr   = 1'($urandom_range(0, 1));
    alu_a_reg     = 1'($urandom_range(0, 1));
    alu_b_sel     = 2'($urandom_range(0, 3));
    pc_src        = 2'($urandom_range(0, 3));
    pc_we         = ($urandom_range(0, 3) == 0);
    pc_we_zero    = 1'($urandom_range(0, 1));
    alu_op        = ops[$urandom_range(0, 4)];
    if (mode == 8) alu_op = 3'($urandom_range(0, 7));
    if (mode == 10) begin alu_op = 3'b111; pc_we = ($urandom_range(0, 7) == 0); end
    if (mode == 5) rf_we = ($urandom_range(0, 7) != 0);
  endtask

  task automatic cycle(input string tag);
    logic [31:0] e_addr, opa, opb, imm, res, rd, n_pc;
    logic [4:0] wa;
    logic e_zero, load;
    #1;
    e_addr = addr_from_alu ? m_out : m_pc;
    imm = {{16{m_ir[15]}}, m_ir[15:0]};
    opa = alu_a_reg ? m_a : m_pc;
    if (alu_b_sel == 0) opb = m_b;
    else if (alu_b_sel == 1) opb = 32'd4;
    else if (alu_b_sel == 2) opb = imm;
    else opb = imm << 2;
    res = ref_alu(alu_op, opa, opb);
    e_zero = (res == 32'd0);
    check(tag, "mem_addr", mem_addr, e_addr);
    check(tag, "mem_wdata", mem_wdata, m_b);
    check(tag, "instr", instr, m_ir);
    check(tag, "alu_zero", {31'd0, alu_zero}, {31'd0, e_zero});
    check(tag, "mem_strobes", {30'd0, mem_rd, mem_wr}, {30'd0, mem_rd_req, mem_wr_req});
    rd = mem[e_addr[7:2]];
    if (pc_src == 0) n_pc = res;
    else if (pc_src == 1) n_pc = m_out;
    else n_pc = {m_pc[31:28], m_ir[25:0], 2'b00};
    load = pc_we || (pc_we_zero && e_zero);
    wa = rf_dst_rd ? m_ir[15:11] : m_ir[20:16];
    @(posedge clk);
    #1;
    if (mem_wr_req) mem[e_addr[7:2]] = m_b;
    m_a = m_rf[m_ir[25:21]];
    m_b = m_rf[m_ir[20:16]];
    if (rf_we && wa != 0) m_rf[wa] = rf_from_mdr ? m_mdr : m_out;
    m_mdr = rd;
    m_out = res;
    if (ir_load) m_ir = rd;
    if (load) m_pc = n_pc;
    @(negedge clk);
  endtask

  task automatic phase(input string tag, input int mode, input int n);
    for (int k = 0; k < n; k++) begin
      randomize_ctrl(mode);
      cycle(tag);
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = i * 32'h9E37_79B9 + 32'h1357_2468;
    for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
    m_pc = 0; m_ir = 0; m_mdr = 0; m_a = 0; m_b = 0; m_out = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "pc after reset", mem_addr, 32'd0);
    check("R1", "B after reset", mem_wdata, 32'd0);
    check("R1", "IR after reset", instr, 32'd0);
    addr_from_alu = 1;
    #1;
    check("R1", "ALUOut after reset", mem_addr, 32'd0);
    addr_from_alu = 0;
    @(negedge clk);
    rst_n = 1'b1;
    ir_load = 1;
    cycle("R3");
    check("R3", "IR loaded from address 0", instr, mem[0]);
    phase("R2", 2, 300);
    phase("R3", 3, 300);
    phase("R4", 4, 300);
    phase("R5", 5, 400);
    phase("R6", 6, 300);
    phase("R7", 7, 300);
    phase("R8", 8, 400);
    phase("R9", 9, 300);
    phase("R10", 10, 400);
    phase("R11", 11, 300);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule